// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block takes one 16-bit instruction halfword per cycle, together with a valid strobe, and splits it into its fields. The two most significant bits pick one of three encodings. Each encoding has its own opcode width and its own set of fields. Register-register operations carry an 8-bit opcode and two 4-bit register indices. Register-immediate operations carry a 2-bit opcode, one register index and an unsigned 8-bit constant. Conditional branches carry a 4-bit opcode and a signed 10-bit halfword displacement.

Besides the fields, the decoder produces three more results. The first is a format tag. The second is the total instruction length: 6 bytes when a 32-bit big-endian constant follows the halfword, and 2 bytes otherwise. The third is an illegal-encoding flag. A fetch unit uses the length to advance its pointer, and an execute stage consumes the fields. All results are registered and appear one cycle after the strobe.

The opcode tables are held in a shared package. A parameter selects how the legality and length lookup is built: either as generated constant vectors indexed by the opcode, or as range comparators.

Top module: `insn_format_decoder`

## Requirements
- R1: `fmt_o` reports the encoding that the top bits select. Bit 15 at 0 gives 1. Bits 15:14 at `10` give 2. Bits 15:14 at `11` give 3.
- R2: For format 1, `opcode_o` = bits 15:8, `reg_a_o` = bits 7:4 and `reg_b_o` = bits 3:0. `imm_o` and `boff_o` read zero.
- R3: For format 2, `opcode_o` = bits 13:12, `reg_a_o` = bits 11:8 and `imm_o` = bits 7:0. `reg_b_o` and `boff_o` read zero. All four format-2 opcodes are legal.
- R4: For format 3, `opcode_o` = bits 13:10 and `boff_o` = the bits 9:0 field, sign-extended to `BOFF_W` bits and multiplied by two. The register and immediate outputs read zero.
- R5: A format-1 opcode is illegal when it equals 0x00, when it lies in 0x10..0x18, or when it is greater than 0x39.
- R6: A format-3 opcode greater than 9 is illegal.
- R7: `len_o` is 6 for the legal format-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36..0x39. `len_o` is 2 for every other word.
- R8: When `illegal_o` is 1, the outputs `opcode_o`, `reg_a_o`, `reg_b_o`, `imm_o` and `boff_o` read zero and `len_o` reads 2. `fmt_o` still names the format.
- R9: A word presented with `insn_vld_i` high is reflected on the outputs after the next rising clock edge, with `out_vld_o` high. A cycle with `insn_vld_i` low gives `out_vld_o` low after that edge and leaves every field output unchanged.
- R10: After reset, `out_vld_o` and `illegal_o` are 0, `fmt_o` and all field outputs are 0, and `len_o` is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | INSN_W | Instruction halfword |
| insn_vld_i | input | 1 | Halfword valid strobe |
| out_vld_o | output | 1 | Decoded result valid |
| fmt_o | output | 2 | Format tag (1, 2 or 3) |
| opcode_o | output | OPC_W | Opcode, zero-extended |
| reg_a_o | output | REG_W | First register index |
| reg_b_o | output | REG_W | Second register index |
| imm_o | output | IMM_W | Unsigned 8-bit immediate |
| boff_o | output | BOFF_W | Signed branch byte offset |
| len_o | output | LEN_W | Total instruction length in bytes |
| illegal_o | output | 1 | Illegal encoding flag |

## Verification
The bench builds the block with its default parameters. These are a 32-bit offset output, a 3-bit length output and the generated-vector lookup style. With these values, sign extension of the 10-bit displacement is visible across the full 32-bit output, at both ends of its range. The vector table walks the opcodes at the edges of every legal and illegal range and exercises each opcode class that adds the 32-bit constant. Directed tests then cover the hold behaviour on idle cycles, the one-cycle latency and a reset that arrives in the middle of a stream.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

   typedef enum logic [1:0] {
      FMT_NONE  = 2'd0,
      FMT_ONE   = 2'd1,
      FMT_TWO   = 2'd2,
      FMT_THREE = 2'd3
   } fmt_e;

   localparam int unsigned F1_OP_BITS  = 7;
   localparam int unsigned F3_OP_BITS  = 4;
   localparam logic [7:0]  F1_LAST_OP  = 8'h39;
   localparam logic [7:0]  F1_GAP_LO   = 8'h10;
   localparam logic [7:0]  F1_GAP_HI   = 8'h18;
   localparam logic [3:0]  F3_LAST_OP  = 4'd9;

   // register-register opcode: is it defined at all
   function automatic logic f1_legal(input logic [7:0] op);
      logic bad;
      bad = (op == 8'h00) || ((op >= F1_GAP_LO) && (op <= F1_GAP_HI)) || (op > F1_LAST_OP);
      return !bad;
   endfunction

   // register-register opcode followed by a 32-bit big-endian constant
   function automatic logic f1_ext(input logic [7:0] op);
      logic hit;
      case (op)
         8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
         8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
         8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: hit = 1'b1;
         default:                                  hit = 1'b0;
      endcase
      return hit;
   endfunction

   function automatic logic f3_legal(input logic [3:0] op);
      return op <= F3_LAST_OP;
   endfunction

endpackage

// File: rtl/ifd_field_split.sv
module ifd_field_split #(
   parameter int unsigned INSN_W = 16,
   parameter int unsigned OPC_W  = 8,
   parameter int unsigned REG_W  = 4,
   parameter int unsigned IMM_W  = 8,
   parameter int unsigned OFF_W  = 10,
   parameter int unsigned BOFF_W = 32
) (
   input  logic [INSN_W-1:0] insn_i,
   output ifd_pkg::fmt_e     fmt_o,
   output logic [OPC_W-1:0]  opc_o,
   output logic [REG_W-1:0]  reg_a_o,
   output logic [REG_W-1:0]  reg_b_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic [BOFF_W-1:0] boff_o
);
   localparam int unsigned TOP   = INSN_W - 1;
   localparam int unsigned SX_W  = BOFF_W - OFF_W - 1;
   localparam int unsigned F1_OH = INSN_W - 1;
   localparam int unsigned F1_OL = 2 * REG_W;
   localparam int unsigned F2_RL = IMM_W;
   localparam int unsigned F3_OL = OFF_W;

   logic [BOFF_W-1:0] sext_off;
   assign sext_off = {{SX_W{insn_i[OFF_W-1]}}, insn_i[OFF_W-1:0], 1'b0};

   always_comb begin
      fmt_o   = ifd_pkg::FMT_NONE;
      opc_o   = '0;
      reg_a_o = '0;
      reg_b_o = '0;
      imm_o   = '0;
      boff_o  = '0;
      if (!insn_i[TOP]) begin
         fmt_o                    = ifd_pkg::FMT_ONE;
         opc_o[F1_OH-F1_OL:0]     = insn_i[F1_OH:F1_OL];
         reg_a_o                  = insn_i[2*REG_W-1:REG_W];
         reg_b_o                  = insn_i[REG_W-1:0];
      end else if (!insn_i[TOP-1]) begin
         fmt_o    = ifd_pkg::FMT_TWO;
         opc_o[1:0] = insn_i[TOP-2:TOP-3];
         reg_a_o  = insn_i[F2_RL+REG_W-1:F2_RL];
         imm_o    = insn_i[IMM_W-1:0];
      end else begin
         fmt_o    = ifd_pkg::FMT_THREE;
         opc_o[TOP-2-F3_OL:0] = insn_i[TOP-2:F3_OL];
         boff_o   = sext_off;
      end
   end
endmodule

// File: rtl/ifd_legality.sv
module ifd_legality #(
   parameter int unsigned OPC_W       = 8,
   parameter int unsigned TABLE_STYLE = 0
) (
   input  ifd_pkg::fmt_e    fmt_i,
   input  logic [OPC_W-1:0] opc_i,
   output logic             illegal_o,
   output logic             ext_o
);
   localparam int unsigned F1_N = 2 ** ifd_pkg::F1_OP_BITS;
   localparam int unsigned F3_N = 2 ** ifd_pkg::F3_OP_BITS;

   logic f1_ok, f1_long, f3_ok, hi_clear;

   // opcode bits above the format-1 field are always zero from the splitter
   assign hi_clear = ~|opc_i[OPC_W-1:ifd_pkg::F1_OP_BITS];

   generate
      if (TABLE_STYLE == 0) begin : g_vec
         logic [F1_N-1:0] ok_vec;
         logic [F1_N-1:0] long_vec;
         logic [F3_N-1:0] br_vec;
         for (genvar gi = 0; gi < F1_N; gi++) begin : g_f1
            assign ok_vec[gi]   = ifd_pkg::f1_legal(8'(gi));
            assign long_vec[gi] = ifd_pkg::f1_ext(8'(gi));
         end
         for (genvar gj = 0; gj < F3_N; gj++) begin : g_f3
            assign br_vec[gj] = ifd_pkg::f3_legal(4'(gj));
         end
         assign f1_ok   = ok_vec[opc_i[ifd_pkg::F1_OP_BITS-1:0]] & hi_clear;
         assign f1_long = long_vec[opc_i[ifd_pkg::F1_OP_BITS-1:0]];
         assign f3_ok   = br_vec[opc_i[ifd_pkg::F3_OP_BITS-1:0]];
      end else begin : g_cmp
         logic [7:0] op8;
         assign op8     = {1'b0, opc_i[ifd_pkg::F1_OP_BITS-1:0]};
         assign f1_ok   = ifd_pkg::f1_legal(op8) & hi_clear;
         assign f1_long = ifd_pkg::f1_ext(op8);
         assign f3_ok   = ifd_pkg::f3_legal(opc_i[ifd_pkg::F3_OP_BITS-1:0]);
      end
   endgenerate

   always_comb begin
      illegal_o = 1'b0;
      ext_o     = 1'b0;
      unique case (fmt_i)
         ifd_pkg::FMT_ONE: begin
            illegal_o = !f1_ok;
            ext_o     = f1_ok & f1_long;
         end
         ifd_pkg::FMT_THREE: illegal_o = !f3_ok;
         default: ;
      endcase
   end
endmodule

// File: rtl/ifd_out_stage.sv
module ifd_out_stage #(
   parameter int unsigned OPC_W     = 8,
   parameter int unsigned REG_W     = 4,
   parameter int unsigned IMM_W     = 8,
   parameter int unsigned BOFF_W    = 32,
   parameter int unsigned LEN_W     = 3,
   parameter int unsigned SHORT_LEN = 2,
   parameter int unsigned LONG_LEN  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  ifd_pkg::fmt_e     fmt_i,
   input  logic [OPC_W-1:0]  opc_i,
   input  logic [REG_W-1:0]  reg_a_i,
   input  logic [REG_W-1:0]  reg_b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [BOFF_W-1:0] boff_i,
   input  logic              illegal_i,
   input  logic              ext_i,
   output logic              vld_o,
   output logic [1:0]        fmt_o,
   output logic [OPC_W-1:0]  opc_o,
   output logic [REG_W-1:0]  reg_a_o,
   output logic [REG_W-1:0]  reg_b_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic [BOFF_W-1:0] boff_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              illegal_o
);
   localparam logic [LEN_W-1:0] LEN_S = LEN_W'(SHORT_LEN);
   localparam logic [LEN_W-1:0] LEN_L = LEN_W'(LONG_LEN);

   logic keep;
   assign keep = !illegal_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o     <= 1'b0;
         fmt_o     <= 2'd0;
         opc_o     <= '0;
         reg_a_o   <= '0;
         reg_b_o   <= '0;
         imm_o     <= '0;
         boff_o    <= '0;
         len_o     <= LEN_S;
         illegal_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            fmt_o     <= fmt_i;
            opc_o     <= keep ? opc_i   : '0;
            reg_a_o   <= keep ? reg_a_i : '0;
            reg_b_o   <= keep ? reg_b_i : '0;
            imm_o     <= keep ? imm_i   : '0;
            boff_o    <= keep ? boff_i  : '0;
            len_o     <= ext_i ? LEN_L : LEN_S;
            illegal_o <= illegal_i;
         end
      end
   end

   p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o);
   p_vld_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !vld_o);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> ($stable(opc_o) && $stable(boff_o) && $stable(len_o) && $stable(fmt_o)));
   p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (opc_o == '0 && reg_a_o == '0 && reg_b_o == '0 &&
                     imm_o == '0 && boff_o == '0 && len_o == LEN_S));
   p_len_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (len_o == LEN_S) || (len_o == LEN_L));
   p_long_only_f1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (len_o == LEN_L) |-> (fmt_o == 2'd1 && !illegal_o));
endmodule

// File: rtl/insn_format_decoder.sv
module insn_format_decoder #(
   parameter int unsigned INSN_W      = 16,
   parameter int unsigned OPC_W       = 8,
   parameter int unsigned REG_W       = 4,
   parameter int unsigned IMM_W       = 8,
   parameter int unsigned OFF_W       = 10,
   parameter int unsigned BOFF_W      = 32,
   parameter int unsigned LEN_W       = 3,
   parameter int unsigned SHORT_LEN   = 2,
   parameter int unsigned EXT_BYTES   = 4,
   parameter int unsigned TABLE_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn_i,
   input  logic              insn_vld_i,
   output logic              out_vld_o,
   output logic [1:0]        fmt_o,
   output logic [OPC_W-1:0]  opcode_o,
   output logic [REG_W-1:0]  reg_a_o,
   output logic [REG_W-1:0]  reg_b_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic [BOFF_W-1:0] boff_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              illegal_o
);
   localparam int unsigned LONG_LEN = SHORT_LEN + EXT_BYTES;

   generate
      if (INSN_W != 16)                 begin : g_bad_insn  $error("INSN_W must be 16"); end
      if (REG_W != 4 || IMM_W != 8)     begin : g_bad_field $error("REG_W/IMM_W fixed by encoding"); end
      if (OFF_W != 10)                  begin : g_bad_off   $error("OFF_W fixed by encoding"); end
      if (OPC_W < 8)                    begin : g_bad_opc   $error("OPC_W must hold 8 bits"); end
      if (BOFF_W < OFF_W + 2)           begin : g_bad_boff  $error("BOFF_W too narrow"); end
      if (LONG_LEN >= (2 ** LEN_W))     begin : g_bad_len   $error("LEN_W too narrow"); end
      if (TABLE_STYLE > 1)              begin : g_bad_style $error("TABLE_STYLE is 0 or 1"); end
   endgenerate

   ifd_pkg::fmt_e     sp_fmt;
   logic [OPC_W-1:0]  sp_opc;
   logic [REG_W-1:0]  sp_ra, sp_rb;
   logic [IMM_W-1:0]  sp_imm;
   logic [BOFF_W-1:0] sp_boff;
   logic              lg_illegal, lg_ext;

   ifd_field_split #(
      .INSN_W(INSN_W), .OPC_W(OPC_W), .REG_W(REG_W),
      .IMM_W(IMM_W), .OFF_W(OFF_W), .BOFF_W(BOFF_W)
   ) u_split (
      .insn_i (insn_i),
      .fmt_o  (sp_fmt),
      .opc_o  (sp_opc),
      .reg_a_o(sp_ra),
      .reg_b_o(sp_rb),
      .imm_o  (sp_imm),
      .boff_o (sp_boff)
   );

   ifd_legality #(
      .OPC_W(OPC_W), .TABLE_STYLE(TABLE_STYLE)
   ) u_legal (
      .fmt_i    (sp_fmt),
      .opc_i    (sp_opc),
      .illegal_o(lg_illegal),
      .ext_o    (lg_ext)
   );

   ifd_out_stage #(
      .OPC_W(OPC_W), .REG_W(REG_W), .IMM_W(IMM_W), .BOFF_W(BOFF_W),
      .LEN_W(LEN_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
   ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (insn_vld_i),
      .fmt_i    (sp_fmt),
      .opc_i    (sp_opc),
      .reg_a_i  (sp_ra),
      .reg_b_i  (sp_rb),
      .imm_i    (sp_imm),
      .boff_i   (sp_boff),
      .illegal_i(lg_illegal),
      .ext_i    (lg_ext),
      .vld_o    (out_vld_o),
      .fmt_o    (fmt_o),
      .opc_o    (opcode_o),
      .reg_a_o  (reg_a_o),
      .reg_b_o  (reg_b_o),
      .imm_o    (imm_o),
      .boff_o   (boff_o),
      .len_o    (len_o),
      .illegal_o(illegal_o)
   );

   p_fmt_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld_i && !insn_i[INSN_W-1]) |=> (fmt_o == 2'd1));
   p_fmt_three_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld_i && insn_i[INSN_W-1:INSN_W-2] == 2'b11) |=> (fmt_o == 2'd3));
   p_f2_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld_i && insn_i[INSN_W-1:INSN_W-2] == 2'b10) |=> (fmt_o == 2'd2 && !illegal_o));
   p_f3_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld_i && insn_i[INSN_W-1:INSN_W-2] == 2'b11 && insn_i[13:10] > 4'd9) |=> illegal_o);
   p_f1_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_vld_i && insn_i[INSN_W-1:8] == '0) |=> illegal_o);
endmodule

// File: tb/insn_format_decoder_tb.sv
module insn_format_decoder_tb;
   typedef struct packed {
      logic [15:0] insn;
      logic [1:0]  fmt;
      logic [7:0]  opc;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic [7:0]  imm;
      logic [31:0] boff;
      logic [2:0]  len;
      logic        ill;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      {16'h0123, 2'd1, 8'h01, 4'h2, 4'h3, 8'h00, 32'h0000_0000, 3'd6, 1'b0},
      {16'h0234, 2'd1, 8'h02, 4'h3, 4'h4, 8'h00, 32'h0000_0000, 3'd2, 1'b0},
      {16'h0000, 2'd1, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b1},
      {16'h1055, 2'd1, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b1},
      {16'h1866, 2'd1, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b1},
      {16'h1977, 2'd1, 8'h19, 4'h7, 4'h7, 8'h00, 32'h0000_0000, 3'd2, 1'b0},
      {16'h39AB, 2'd1, 8'h39, 4'hA, 4'hB, 8'h00, 32'h0000_0000, 3'd6, 1'b0},
      {16'h3A12, 2'd1, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b1},
      {16'h7FFF, 2'd1, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b1},
      {16'h0F00, 2'd1, 8'h0F, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b0},
      {16'h3001, 2'd1, 8'h30, 4'h0, 4'h1, 8'h00, 32'h0000_0000, 3'd6, 1'b0},
      {16'h1A00, 2'd1, 8'h1A, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd6, 1'b0},
      {16'h2500, 2'd1, 8'h25, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b0},
      {16'h0D00, 2'd1, 8'h0D, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd6, 1'b0},
      {16'h0E21, 2'd1, 8'h0E, 4'h2, 4'h1, 8'h00, 32'h0000_0000, 3'd2, 1'b0},
      {16'h3612, 2'd1, 8'h36, 4'h1, 4'h2, 8'h00, 32'h0000_0000, 3'd6, 1'b0},
      {16'h8A5C, 2'd2, 8'h00, 4'hA, 4'h0, 8'h5C, 32'h0000_0000, 3'd2, 1'b0},
      {16'hBFFF, 2'd2, 8'h03, 4'hF, 4'h0, 8'hFF, 32'h0000_0000, 3'd2, 1'b0},
      {16'hC3FF, 2'd3, 8'h00, 4'h0, 4'h0, 8'h00, 32'hFFFF_FFFE, 3'd2, 1'b0},
      {16'hC200, 2'd3, 8'h00, 4'h0, 4'h0, 8'h00, 32'hFFFF_FC00, 3'd2, 1'b0},
      {16'hC1FF, 2'd3, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_03FE, 3'd2, 1'b0},
      {16'hE405, 2'd3, 8'h09, 4'h0, 4'h0, 8'h00, 32'h0000_000A, 3'd2, 1'b0},
      {16'hE800, 2'd3, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b1},
      {16'hFFFF, 2'd3, 8'h00, 4'h0, 4'h0, 8'h00, 32'h0000_0000, 3'd2, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] insn = '0;
   logic        vld = 1'b0;
   logic        out_vld, illegal;
   logic [1:0]  fmt;
   logic [7:0]  opc, imm;
   logic [3:0]  ra, rb;
   logic [31:0] boff;
   logic [2:0]  len;
   int          n_chk = 0;
   int          n_bad = 0;

   always #5 clk = ~clk;

   insn_format_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .insn_i(insn), .insn_vld_i(vld),
      .out_vld_o(out_vld), .fmt_o(fmt), .opcode_o(opc), .reg_a_o(ra),
      .reg_b_o(rb), .imm_o(imm), .boff_o(boff), .len_o(len), .illegal_o(illegal)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input vec_t v);
      if (v.fmt == 2'd1 && v.ill) return "R5 R8";
      if (v.fmt == 2'd1 && v.len == 3'd6) return "R7 R2";
      if (v.fmt == 2'd1) return "R2";
      if (v.fmt == 2'd2) return "R3";
      if (v.ill) return "R6 R8";
      return "R4";
   endfunction

   task automatic chk_vec(input vec_t v);
      string t;
      t = tag_of(v);
      chk("R9", "out_vld", 32'(out_vld), 32'd1);
      chk("R1", "fmt",     32'(fmt),     32'(v.fmt));
      chk(t,    "opcode",  32'(opc),     32'(v.opc));
      chk(t,    "reg_a",   32'(ra),      32'(v.ra));
      chk(t,    "reg_b",   32'(rb),      32'(v.rb));
      chk(t,    "imm",     32'(imm),     32'(v.imm));
      chk(t,    "boff",    boff,         v.boff);
      chk("R7", "len",     32'(len),     32'(v.len));
      chk(t,    "illegal", 32'(illegal), 32'(v.ill));
   endtask

   task automatic chk_reset_state(input string why);
      chk("R10", {why, " out_vld"}, 32'(out_vld), 32'd0);
      chk("R10", {why, " illegal"}, 32'(illegal), 32'd0);
      chk("R10", {why, " fmt"},     32'(fmt),     32'd0);
      chk("R10", {why, " opcode"},  32'(opc),     32'd0);
      chk("R10", {why, " regs"},    32'({ra, rb}), 32'd0);
      chk("R10", {why, " imm"},     32'(imm),     32'd0);
      chk("R10", {why, " boff"},    boff,         32'd0);
      chk("R10", {why, " len"},     32'(len),     32'd2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_reset_state("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset_state("after reset");

      // table walk, back-to-back valid words
      insn = VEC[0].insn;
      vld  = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         chk_vec(VEC[i]);
         if (i + 1 < NV) insn = VEC[i+1].insn;
      end

      // R9: idle cycles hold the last result (VEC[NV-1] then a fresh one)
      insn = 16'hC3FF;
      @(negedge clk);
      chk_vec(VEC[18]);
      vld  = 1'b0;
      insn = 16'h0123;
      repeat (2) begin
         @(negedge clk);
         chk("R9", "idle out_vld", 32'(out_vld), 32'd0);
         chk("R9", "idle boff held", boff, 32'hFFFF_FFFE);
         chk("R9", "idle fmt held", 32'(fmt), 32'd3);
         chk("R9", "idle len held", 32'(len), 32'd2);
      end

      // R9: nothing changes before the edge, result after it
      vld = 1'b1;
      #1;
      chk("R9", "pre-edge out_vld", 32'(out_vld), 32'd0);
      chk("R9", "pre-edge fmt", 32'(fmt), 32'd3);
      @(negedge clk);
      chk_vec(VEC[0]);

      // R10: reset in the middle of a stream
      insn = 16'h39AB;
      #2;
      rst_n = 1'b0;
      #1;
      chk_reset_state("mid-stream");
      @(negedge clk);
      chk_reset_state("held reset");
      rst_n = 1'b1;
      vld   = 1'b0;
      @(negedge clk);
      chk_reset_state("released idle");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule